// File: doc/BRIEF.md
# Free-Running Capture/Compare Timer

This block is a timer subsystem for a microcontroller-class chip. A free-running up-counter advances at the system clock divided by a selectable prescale ratio. Software may read the counter but cannot write it. Around the counter sit input-capture channels, output-compare channels, an overflow event and a periodic real-time tick taken from the same counter chain.

Each capture channel passes its pin through a two-flop synchronizer and then through an edge detector. On the selected transition it latches the counter into its own register. Each compare channel holds a target value. When the counter reaches that value the channel raises its flag and applies its configured action to its output pin.

Every event has a flag bit, cleared by writing 1 to it, and an enable bit. The interrupt vector is the bitwise AND of flags and enables. Software reaches all of it through a simple word-wide register bus with a combinational read path.

Top module: `capcmp_timer`

## Requirements
- R1: The counter starts at 0 after reset and increments by one on every prescaler tick. Writes to the counter address (0) have no effect.
- R2: Prescale field bits [1:0] at address 1 select the divide ratio: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 16. Any 64 consecutive clocks therefore advance the counter by 64 divided by that ratio.
- R3: The overflow flag (flag bit 8) sets in the same clock edge in which the counter wraps from 0xFFFF to 0x0000.
- R4: A capture channel k latches into its register (address 8+k) the counter value present two clock edges after its pin changes. Flag bit k sets in the same cycle.
- R5: Capture mode field bits [2k+1:2k] at address 2 select the trigger: 0 off, 1 rising, 2 falling, 3 both. On a non-selected edge the register and the flag are unchanged.
- R6: Compare channel j, with its value at address 16+j, sets flag bit 3+j at the edge where the counter becomes equal to that value.
- R7: At that match the action field bits [2j+1:2j] at address 3 drive pin j as follows: 0 leaves it unchanged, 1 toggles it, 2 drives it low, 3 drives it high.
- R8: The real-time flag (bit 9) sets every 2^(4+s) counter ticks, where s is bits [3:2] of address 1.
- R9: Writing 1 to a bit of the flag register (address 4) clears that flag, and writing 0 has no effect. A flag that is set in the same cycle as the clear stays set.
- R10: The interrupt vector bit i is high exactly when flag bit i and enable bit i (address 5, same layout as the flags) are both set.
- R11: During reset all flags, enables and compare pins are 0, the interrupt vector is 0 and the counter reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| cap_pin | input | 3 | Asynchronous capture inputs |
| cmp_pin | output | 5 | Compare-driven output pins |
| irq_vec | output | 10 | Per-event interrupts: capture 0-2, compare 3-7, overflow 8, real-time 9 |

## Verification
The counter changes at the first edge after a tick. A capture appears three edges after the pin moves and holds the count that was current two edges after it. A compare flag and its pin both change at the edge where the counter reaches the target. The overflow and real-time flags rise at the same edge as the counter move that causes them, and a register write takes effect at the next edge. The bench reads the counter just before each stimulus and derives every expected value from that reading and the exact number of edges between stimulus and sample. It samples one clock before the due edge, where nothing may have changed yet, and again right after it. Real-time periods are measured as the distance in clocks between two successive flag rises.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Shared encodings and register addresses for the capture/compare timer.
package tmr_pkg;

    // Capture trigger selection per channel.
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_e;

    // Pin action applied on a compare match.
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_LOW    = 2'd2,
        ACT_HIGH   = 2'd3
    } pin_act_e;

    // Register addresses (word addresses on the timer bus).
    localparam int A_COUNT   = 0;
    localparam int A_PRESC   = 1;
    localparam int A_CAPEDGE = 2;
    localparam int A_CMPACT  = 3;
    localparam int A_FLAGS   = 4;
    localparam int A_IEN     = 5;
    localparam int A_CAP0    = 8;
    localparam int A_CMP0    = 16;

endpackage

// File: rtl/tmr_base.sv
`timescale 1ns/1ps
// Prescaler, free-running counter and the event taps on the counter chain.
// Assumes RTI_BASE + 3 < CNT_W so that every real-time period fits the counter.
module tmr_base #(
    parameter int CNT_W    = 16,
    parameter int RTI_BASE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       pre_sel,
    input  logic [1:0]       rti_sel,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_nxt,
    output logic             tick,
    output logic             ovf_evt,
    output logic             rti_evt
);
    localparam int PDIV_W = 4;

    logic [PDIV_W-1:0] pdiv;
    logic [CNT_W-1:0]  rti_mask;

    // Free-running prescale divider.
    always_ff @(posedge clk) begin
        if (!rst_n) pdiv <= '0;
        else        pdiv <= pdiv + PDIV_W'(1);
    end

    // Tick selection: divide by 1, 4, 8 or 16.
    always_comb begin
        case (pre_sel)
            2'd0:    tick = 1'b1;
            2'd1:    tick = &pdiv[1:0];
            2'd2:    tick = &pdiv[2:0];
            default: tick = &pdiv[3:0];
        endcase
    end

    assign count_nxt = count + CNT_W'(1);

    // Main counter, advanced only by the prescaler tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (tick) count <= count_nxt;
    end

    assign ovf_evt  = tick && (&count);
    assign rti_mask = (CNT_W'(1) << (RTI_BASE + int'(rti_sel))) - CNT_W'(1);
    assign rti_evt  = tick && ((count_nxt & rti_mask) == '0);

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (count == $past(count) + CNT_W'(1)));
    p_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pre_sel != 2'd0) |=> (!tick || !$stable(pre_sel)));

endmodule

// File: rtl/tmr_capture.sv
`timescale 1ns/1ps
// One input-capture channel: synchronizer, edge detector and capture latch.
// Assumes the pin is asynchronous; it is sampled through two flops first.
module tmr_capture
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  edge_mode_e       mode,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_val,
    output logic             fire
);
    logic s1, s2, s3;
    logic rise, fall;

    // Two-flop synchronizer plus a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pin_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise = s2 && !s3;
    assign fall = !s2 && s3;

    // Trigger decision from the selected edge mode.
    always_comb begin
        case (mode)
            EDGE_RISE: fire = rise;
            EDGE_FALL: fire = fall;
            EDGE_BOTH: fire = rise || fall;
            default:   fire = 1'b0;
        endcase
    end

    // Capture latch.
    always_ff @(posedge clk) begin
        if (!rst_n)    cap_val <= '0;
        else if (fire) cap_val <= count;
    end

    p_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cap_val == $past(count)));
    p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(cap_val));

endmodule

// File: rtl/tmr_compare.sv
`timescale 1ns/1ps
// One output-compare channel: match detection and automatic pin action.
// Assumes count_nxt is the value the counter takes when tick is high.
module tmr_compare
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cmp_val,
    input  pin_act_e         act,
    input  logic [CNT_W-1:0] count_nxt,
    input  logic             tick,
    output logic             match,
    output logic             pin
);
    assign match = tick && (count_nxt == cmp_val);

    // Pin update on a match according to the configured action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else if (match) begin
            case (act)
                ACT_TOGGLE: pin <= !pin;
                ACT_LOW:    pin <= 1'b0;
                ACT_HIGH:   pin <= 1'b1;
                default:    pin <= pin;
            endcase
        end
    end

    p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (match && act == ACT_TOGGLE) |=> (pin != $past(pin)));
    p_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (match && act == ACT_HIGH) |=> pin);
    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !match |=> $stable(pin));

endmodule

// File: rtl/capcmp_timer.sv
`timescale 1ns/1ps
// Timer top: register bus, flag/enable logic, and the capture/compare channels.
// Flag layout: capture channels first, then compare, then overflow, then real-time.
// Assumes 2*N_CMP, 2*N_CAP and the flag count all fit in CNT_W bits.
module capcmp_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int N_CAP    = 3,
    parameter int N_CMP    = 5,
    parameter int RTI_BASE = 4,
    parameter int AW       = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_we,
    input  logic [AW-1:0]            bus_addr,
    input  logic [CNT_W-1:0]         bus_wdata,
    output logic [CNT_W-1:0]         bus_rdata,
    input  logic [N_CAP-1:0]         cap_pin,
    output logic [N_CMP-1:0]         cmp_pin,
    output logic [N_CAP+N_CMP+1:0]   irq_vec
);
    localparam int NF      = N_CAP + N_CMP + 2;
    localparam int OVF_BIT = N_CAP + N_CMP;
    localparam int RTI_BIT = OVF_BIT + 1;

    logic [1:0]         pre_sel, rti_sel;
    logic [2*N_CAP-1:0] cap_edge;
    logic [2*N_CMP-1:0] cmp_act;
    logic [CNT_W-1:0]   cmp_reg [N_CMP];
    logic [CNT_W-1:0]   cap_val [N_CAP];
    logic [NF-1:0]      flags, ien, set_vec, clr_vec;
    logic [N_CAP-1:0]   cap_fire;
    logic [N_CMP-1:0]   cmp_match;
    logic [CNT_W-1:0]   count, count_nxt;
    logic               tick, ovf_evt, rti_evt;
    int                 addr_i;

    assign addr_i = int'(bus_addr);

    tmr_base #(.CNT_W(CNT_W), .RTI_BASE(RTI_BASE)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_sel   (pre_sel),
        .rti_sel   (rti_sel),
        .count     (count),
        .count_nxt (count_nxt),
        .tick      (tick),
        .ovf_evt   (ovf_evt),
        .rti_evt   (rti_evt)
    );

    for (genvar i = 0; i < N_CAP; i++) begin : g_cap
        tmr_capture #(.CNT_W(CNT_W)) u_cap (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_in  (cap_pin[i]),
            .mode    (edge_mode_e'(cap_edge[2*i +: 2])),
            .count   (count),
            .cap_val (cap_val[i]),
            .fire    (cap_fire[i])
        );
    end

    for (genvar j = 0; j < N_CMP; j++) begin : g_cmp
        tmr_compare #(.CNT_W(CNT_W)) u_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmp_val   (cmp_reg[j]),
            .act       (pin_act_e'(cmp_act[2*j +: 2])),
            .count_nxt (count_nxt),
            .tick      (tick),
            .match     (cmp_match[j]),
            .pin       (cmp_pin[j])
        );
    end

    // Configuration and compare-value registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_sel  <= '0;
            rti_sel  <= '0;
            cap_edge <= '0;
            cmp_act  <= '0;
            ien      <= '0;
            for (int j = 0; j < N_CMP; j++) cmp_reg[j] <= '0;
        end else if (bus_we) begin
            if (addr_i == A_PRESC) begin
                pre_sel <= bus_wdata[1:0];
                rti_sel <= bus_wdata[3:2];
            end
            if (addr_i == A_CAPEDGE) cap_edge <= bus_wdata[2*N_CAP-1:0];
            if (addr_i == A_CMPACT)  cmp_act  <= bus_wdata[2*N_CMP-1:0];
            if (addr_i == A_IEN)     ien      <= bus_wdata[NF-1:0];
            for (int j = 0; j < N_CMP; j++)
                if (addr_i == A_CMP0 + j) cmp_reg[j] <= bus_wdata;
        end
    end

    assign set_vec = {rti_evt, ovf_evt, cmp_match, cap_fire};
    assign clr_vec = (bus_we && addr_i == A_FLAGS) ? bus_wdata[NF-1:0] : '0;

    // Event flags: write-one-to-clear, a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_vec) | set_vec;
    end

    assign irq_vec = flags & ien;

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        if (addr_i == A_COUNT)   bus_rdata = count;
        if (addr_i == A_PRESC)   bus_rdata[3:0] = {rti_sel, pre_sel};
        if (addr_i == A_CAPEDGE) bus_rdata[2*N_CAP-1:0] = cap_edge;
        if (addr_i == A_CMPACT)  bus_rdata[2*N_CMP-1:0] = cmp_act;
        if (addr_i == A_FLAGS)   bus_rdata[NF-1:0] = flags;
        if (addr_i == A_IEN)     bus_rdata[NF-1:0] = ien;
        for (int i = 0; i < N_CAP; i++)
            if (addr_i == A_CAP0 + i) bus_rdata = cap_val[i];
        for (int j = 0; j < N_CMP; j++)
            if (addr_i == A_CMP0 + j) bus_rdata = cmp_reg[j];
    end

    p_ovf_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[OVF_BIT]) |-> (count == '0 && $past(count) == '1));
    p_rti_needs_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[RTI_BIT]) |-> ($past(tick) && count != $past(count)));

    for (genvar k = 0; k < NF; k++) begin : g_flag_chk
        p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && addr_i == A_FLAGS && bus_wdata[k] && !set_vec[k]) |=> !flags[k]);
        p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[k] |=> flags[k]);
    end

endmodule

// File: tb/capcmp_timer_test.sv
`timescale 1ns/1ps
// Self-checking bench for capcmp_timer: sweeps prescale, real-time rates,
// capture modes per channel and compare actions per channel.
module capcmp_timer_test;
    import tmr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  cap_pin = '0;
    logic [4:0]  cmp_pin;
    logic [9:0]  irq_vec;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    capcmp_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_pin(cap_pin),
        .cmp_pin(cmp_pin), .irq_vec(irq_vec)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(int a, logic [15:0] d);
        bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(int a, output logic [15:0] v);
        bus_addr = 5'(a);
        #0.4;
        v = bus_rdata;
    endtask

    task automatic wait_flag(int b, output int t);
        logic [15:0] f;
        t = -1;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            rd(A_FLAGS, f);
            if (f[b]) begin t = cyc; return; end
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] c0, c1, v, f;
        int t0, t1;
        logic [4:0] exp_pin;

        // R11: reset state
        repeat (3) @(negedge clk);
        rd(A_COUNT, v);
        check("R11", "count in reset", v, 0);
        check("R11", "cmp pins in reset", cmp_pin, 0);
        check("R11", "irq in reset", irq_vec, 0);
        rd(A_FLAGS, v);
        check("R11", "flags in reset", v, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_COUNT, v);
        check("R1", "count after first edge", v, 1);

        // R1: writes to the counter are ignored
        rd(A_COUNT, c0);
        wr(A_COUNT, 16'h1234);
        repeat (4) @(negedge clk);
        rd(A_COUNT, c1);
        check("R1", "count after write attempt", c1, 16'(c0 + 5));

        // R2: prescale ratios
        for (int s = 0; s < 4; s++) begin
            wr(A_PRESC, 16'(s));
            repeat (3) @(negedge clk);
            rd(A_COUNT, c0);
            repeat (64) @(negedge clk);
            rd(A_COUNT, c1);
            check("R2", $sformatf("advance over 64 clk sel=%0d", s), 16'(c1 - c0),
                  (s == 0) ? 64 : 64 / (1 << (s + 1)));
        end

        // R8: real-time periods, divide by 1 and one case at divide by 4
        for (int s = 0; s < 5; s++) begin
            int sel = (s < 4) ? s : 0;
            int pre = (s < 4) ? 0 : 1;
            wr(A_PRESC, 16'((sel << 2) | pre));
            wr(A_FLAGS, 16'h3FF);
            wait_flag(9, t0);
            wr(A_FLAGS, 16'h200);
            wait_flag(9, t1);
            check("R8", $sformatf("rti period sel=%0d pre=%0d", sel, pre), t1 - t0,
                  (16 << sel) * ((pre == 0) ? 1 : 4));
        end
        wr(A_PRESC, 16'h0);

        // R4 / R5: capture sweep over channels, modes and edge direction
        for (int ch = 0; ch < 3; ch++) begin
            for (int m = 0; m < 4; m++) begin
                for (int e = 0; e < 2; e++) begin
                    bit trig;
                    wr(A_CAPEDGE, 16'h0);
                    cap_pin[ch] = (e == 1);
                    repeat (4) @(negedge clk);
                    wr(A_CAPEDGE, 16'(m << (2 * ch)));
                    wr(A_FLAGS, 16'h3FF);
                    rd(A_CAP0 + ch, c1);
                    rd(A_COUNT, c0);
                    cap_pin[ch] = ~cap_pin[ch];
                    repeat (6) @(negedge clk);
                    rd(A_CAP0 + ch, v);
                    rd(A_FLAGS, f);
                    trig = (m == 3) || (m == 1 && e == 0) || (m == 2 && e == 1);
                    if (trig) begin
                        check("R4", $sformatf("cap value ch%0d mode%0d edge%0d", ch, m, e), v, 16'(c0 + 2));
                        check("R4", $sformatf("cap flag ch%0d mode%0d edge%0d", ch, m, e), f[ch], 1);
                    end else begin
                        check("R5", $sformatf("cap ignored ch%0d mode%0d edge%0d", ch, m, e), v, c1);
                        check("R5", $sformatf("no flag ch%0d mode%0d edge%0d", ch, m, e), f[ch], 0);
                    end
                end
            end
        end
        wr(A_CAPEDGE, 16'h0);

        // R6 / R7 / R10: compare sweep with a sequence of pin actions
        exp_pin = '0;
        for (int ch = 0; ch < 5; ch++) begin
            for (int q = 0; q < 5; q++) begin
                int act;
                logic new_pin;
                case (q)
                    0: act = 3;
                    1: act = 0;
                    2: act = 1;
                    3: act = 1;
                    default: act = 2;
                endcase
                case (act)
                    1: new_pin = ~exp_pin[ch];
                    2: new_pin = 1'b0;
                    3: new_pin = 1'b1;
                    default: new_pin = exp_pin[ch];
                endcase
                wr(A_CMPACT, 16'(act << (2 * ch)));
                wr(A_IEN, 16'(1 << (3 + ch)));
                wr(A_FLAGS, 16'h3FF);
                rd(A_COUNT, c0);
                wr(A_CMP0 + ch, 16'(c0 + 20));
                repeat (18) @(negedge clk);
                rd(A_FLAGS, f);
                check("R6", $sformatf("no early flag ch%0d step%0d", ch, q), f[3 + ch], 0);
                check("R7", $sformatf("pin before match ch%0d step%0d", ch, q), cmp_pin[ch], exp_pin[ch]);
                @(negedge clk);
                rd(A_FLAGS, f);
                check("R6", $sformatf("match flag ch%0d step%0d", ch, q), f[3 + ch], 1);
                check("R7", $sformatf("pin after match ch%0d act%0d", ch, act), cmp_pin[ch], new_pin);
                check("R10", $sformatf("irq enabled ch%0d", ch), irq_vec[3 + ch], 1);
                exp_pin[ch] = new_pin;
            end
        end
        wr(A_IEN, 16'h0);
        check("R10", "irq masked with flag set", irq_vec, 0);

        // R3 / R9 / R10: overflow flag at wrap, clear semantics
        wr(A_FLAGS, 16'h3FF);
        begin
            int k = 0;
            do begin
                @(negedge clk);
                rd(A_COUNT, v);
                k++;
            end while (v != 16'hFFFF && k < 70000);
        end
        rd(A_FLAGS, f);
        check("R3", "no overflow flag before wrap", f[8], 0);
        @(negedge clk);
        rd(A_COUNT, v);
        check("R3", "count wrapped", v, 0);
        rd(A_FLAGS, f);
        check("R3", "overflow flag at wrap", f[8], 1);
        wr(A_IEN, 16'h100);
        check("R10", "overflow irq enabled", irq_vec[8], 1);
        wr(A_IEN, 16'h0);
        check("R10", "overflow irq disabled", irq_vec[8], 0);
        wr(A_FLAGS, 16'h0);
        rd(A_FLAGS, f);
        check("R9", "writing zero keeps flag", f[8], 1);
        wr(A_FLAGS, 16'h100);
        rd(A_FLAGS, f);
        check("R9", "writing one clears flag", f[8], 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule